// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines from peripherals and presents them to a processor core. Each line has an enable bit and a routing bit. The routing bit sends the line either to the normal interrupt output or to the fast interrupt output. A table of priority slots holds a programmable ranking. Each slot names one source, and a lower slot index ranks higher. From that table the block reports the highest-ranked active normal interrupt in one register. That register carries a valid flag and a source number.

Software reaches every register through a plain single-cycle port. A write takes effect at the clock edge where `bus_we` is high. Read data is combinational on `bus_addr` and is valid in the same cycle. The port has no back-pressure: every access completes in one cycle and nothing is ever held off. Source lines are sampled through one register stage. Pending state follows the live lines, so a source goes quiet only when the peripheral drops its line or software masks it. A control bit picks which sources can wake the core from idle: all raw pending sources, or only the enabled ones.

Top module: `prio_intc`

## Requirements
- R1: After reset, the enable, routing and control registers read 0. Every priority slot reads 0, meaning invalid. The winner register reads 0, and `irq_out`, `fiq_out` and `idle_wake` are low while the source lines are low.
- R2: The raw pending word (offset 0x000) equals the source lines as sampled at the previous clock edge. It does not depend on enable or routing.
- R3: The enable word sits at offset 0x004, and bit n set to 1 enables source n. The normal pending word (offset 0x010) equals raw AND enable AND NOT routing. The routing word sits at offset 0x008.
- R4: The fast pending word (offset 0x00C) equals raw AND enable AND routing. A routing bit of 1 selects the fast path.
- R5: `irq_out` is high exactly when the normal pending word is non-zero. `fiq_out` is high exactly when the fast pending word is non-zero.
- R6: The winner register (offset 0x018) has bit 31 set when some valid slot names a source that is in the normal pending word. Its bits 30:16 then hold the source named by the lowest-indexed such slot, and all its other bits are 0.
- R7: When no valid slot names a normal-pending source, the winner register reads 0. This holds when the only such slot is invalid, and when the source is pending only on the fast path.
- R8: Slot k sits at offset 0x01C + 4k. Its bit 31 is the valid flag and bits 4:0 are the source number. Its other bits always read 0.
- R9: The control word sits at offset 0x014. With control bit 0 at 1, `idle_wake` is high exactly when raw AND enable is non-zero. With control bit 0 at 0, `idle_wake` is high exactly when raw is non-zero.
- R10: Writes to the read-only offsets 0x000, 0x00C, 0x010 and 0x018 change no state. Unmapped offsets read 0.
- R11: A source line that falls clears its raw pending bit one cycle later, with no software action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Level-sensitive interrupt lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| irq_out | output | 1 | Normal interrupt request to the core |
| fiq_out | output | 1 | Fast interrupt request to the core |
| idle_wake | output | 1 | Wake request for an idle core |

## Verification
A corrupt enable or routing bit shows up the cycle after the source is sampled. It appears in the two pending words, on `irq_out` or `fiq_out`, and in `idle_wake` when control bit 0 is set. A slot holding the wrong source or valid flag, or a slot scan in the wrong order, shows up only as a wrong winner register. That happens only when two or more ranked sources are active together, so the bench builds overlapping patterns and then removes the leading source. A pending stage that holds a value too long shows up one cycle after a source line falls.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W = 32;
  // byte offsets whose placement software depends on
  localparam int OFF_RAW    = 'h000;
  localparam int OFF_ENABLE = 'h004;
  localparam int OFF_ROUTE  = 'h008;
  localparam int OFF_FAST   = 'h00C;
  localparam int OFF_NORM   = 'h010;
  localparam int OFF_CTRL   = 'h014;
  localparam int OFF_WIN    = 'h018;
  localparam int OFF_SLOT0  = 'h01C;
  localparam int VALID_BIT  = 31;
  localparam int WIN_LSB    = 16;
  localparam int WIN_W      = 15;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 32,
  parameter int ADDR_W    = 8,
  parameter int SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              src_in,
  input  logic                            bus_we,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [DATA_W-1:0]               bus_wdata,
  output logic [DATA_W-1:0]               bus_rdata,
  input  logic                            win_valid,
  input  logic [SRC_W-1:0]                win_src,
  output logic [NUM_SRC-1:0]              raw_q,
  output logic [NUM_SRC-1:0]              enable_q,
  output logic [NUM_SRC-1:0]              norm_pend,
  output logic [NUM_SRC-1:0]              fast_pend,
  output logic                            wake_enabled_only,
  output logic [NUM_SLOTS-1:0]            slot_vld,
  output logic [NUM_SLOTS-1:0][SRC_W-1:0] slot_src
);
  localparam int WORD_W    = ADDR_W - 2;
  localparam int SLOT_WORD = OFF_SLOT0 / 4;

  logic [NUM_SRC-1:0] route_q;
  logic               ctrl_q;
  logic [WORD_W-1:0]  word;
  int                 slot_idx;
  logic               slot_hit;

  assign word     = bus_addr[ADDR_W-1:2];
  assign slot_idx = int'(word) - SLOT_WORD;
  assign slot_hit = (int'(word) >= SLOT_WORD) && (slot_idx < NUM_SLOTS);

  logic unused_low;
  assign unused_low = ^{bus_addr[1:0], bus_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q    <= '0;
      enable_q <= '0;
      route_q  <= '0;
      ctrl_q   <= 1'b0;
    end else begin
      raw_q <= src_in;
      if (bus_we && int'(word) == OFF_ENABLE / 4) enable_q <= bus_wdata[NUM_SRC-1:0];
      if (bus_we && int'(word) == OFF_ROUTE / 4)  route_q  <= bus_wdata[NUM_SRC-1:0];
      if (bus_we && int'(word) == OFF_CTRL / 4)   ctrl_q   <= bus_wdata[0];
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_vld[g] <= 1'b0;
        slot_src[g] <= '0;
      end else if (bus_we && slot_hit && slot_idx == g) begin
        slot_vld[g] <= bus_wdata[VALID_BIT];
        slot_src[g] <= bus_wdata[SRC_W-1:0];
      end
    end
  end

  assign norm_pend         = raw_q & enable_q & ~route_q;
  assign fast_pend         = raw_q & enable_q & route_q;
  assign wake_enabled_only = ctrl_q;

  always_comb begin
    bus_rdata = '0;
    if (slot_hit) begin
      bus_rdata[VALID_BIT]   = slot_vld[slot_idx];
      bus_rdata[SRC_W-1:0]   = slot_src[slot_idx];
    end else begin
      case (int'(word))
        OFF_RAW / 4:    bus_rdata[NUM_SRC-1:0] = raw_q;
        OFF_ENABLE / 4: bus_rdata[NUM_SRC-1:0] = enable_q;
        OFF_ROUTE / 4:  bus_rdata[NUM_SRC-1:0] = route_q;
        OFF_FAST / 4:   bus_rdata[NUM_SRC-1:0] = fast_pend;
        OFF_NORM / 4:   bus_rdata[NUM_SRC-1:0] = norm_pend;
        OFF_CTRL / 4:   bus_rdata[0]           = ctrl_q;
        OFF_WIN / 4: begin
          bus_rdata[VALID_BIT]              = win_valid;
          bus_rdata[WIN_LSB +: SRC_W]       = win_src;
        end
        default: bus_rdata = '0;
      endcase
    end
  end

  // R11: pending tracks the sampled line with one stage of delay
  p_pend_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> raw_q == $past(src_in));

  // R10: a write to the raw offset leaves enable untouched
  p_ro_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bus_we) && $past(int'(word)) == OFF_RAW / 4) |-> $stable(enable_q));
endmodule

// File: rtl/intc_rank.sv
module intc_rank
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 32,
  parameter int SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              norm_pend,
  input  logic [NUM_SLOTS-1:0]            slot_vld,
  input  logic [NUM_SLOTS-1:0][SRC_W-1:0] slot_src,
  output logic                            win_valid,
  output logic [SRC_W-1:0]                win_src
);
  logic [NUM_SLOTS-1:0] live;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_live
    assign live[g] = slot_vld[g] && norm_pend[slot_src[g]];
  end

  // scan from the lowest rank upward so the lowest slot index is written last
  always_comb begin
    win_valid = 1'b0;
    win_src   = '0;
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      if (live[k]) begin
        win_valid = 1'b1;
        win_src   = slot_src[k];
      end
    end
  end

  // R6: a reported winner is a source that is currently normal-pending
  p_win_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> norm_pend[win_src]);

  // R7: with nothing normal-pending there is never a winner
  p_no_win_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_pend == '0) |-> !win_valid && win_src == '0);
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 32,
  parameter int ADDR_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_out,
  output logic               fiq_out,
  output logic               idle_wake
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0]              raw_q, enable_q, norm_pend, fast_pend;
  logic                            wake_enabled_only;
  logic [NUM_SLOTS-1:0]            slot_vld;
  logic [NUM_SLOTS-1:0][SRC_W-1:0] slot_src;
  logic                            win_valid;
  logic [SRC_W-1:0]                win_src;

  intc_regs #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .win_valid(win_valid), .win_src(win_src),
    .raw_q(raw_q), .enable_q(enable_q), .norm_pend(norm_pend), .fast_pend(fast_pend),
    .wake_enabled_only(wake_enabled_only), .slot_vld(slot_vld), .slot_src(slot_src)
  );

  intc_rank #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS), .SRC_W(SRC_W)) u_rank (
    .clk(clk), .rst_n(rst_n), .norm_pend(norm_pend),
    .slot_vld(slot_vld), .slot_src(slot_src),
    .win_valid(win_valid), .win_src(win_src)
  );

  assign irq_out   = |norm_pend;
  assign fiq_out   = |fast_pend;
  assign idle_wake = wake_enabled_only ? |(raw_q & enable_q) : |raw_q;

  // R6: a winner always comes with a normal interrupt request
  p_win_has_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> irq_out);

  // R3: with every source disabled neither request line is raised
  p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0) |-> !irq_out && !fiq_out);

  // R9: in enabled-only mode no wake without an enabled source
  p_wake_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_enabled_only && enable_q == '0) |-> !idle_wake);
endmodule

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out, fiq_out, idle_wake;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  prio_intc u_prio_intc (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .fiq_out(fiq_out), .idle_wake(idle_wake)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic drive(input logic [31:0] s);
    @(negedge clk);
    src_in = s;
    @(negedge clk);
  endtask

  function automatic logic [31:0] win(input int s);
    return 32'h8000_0000 | (32'(s) << 16);
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h04, v); check("R1 enable", v, 0);
    rd(8'h08, v); check("R1 route", v, 0);
    rd(8'h14, v); check("R1 ctrl", v, 0);
    rd(8'h1C, v); check("R1 slot0", v, 0);
    rd(8'h98, v); check("R1 slot31", v, 0);
    rd(8'h18, v); check("R1 winner", v, 0);
    check("R1 outs", {29'b0, irq_out, fiq_out, idle_wake}, 0);
  endtask

  task automatic t_raw;
    logic [31:0] v;
    drive(32'h0000_00A5);
    rd(8'h00, v); check("R2 raw", v, 32'h0000_00A5);
    rd(8'h10, v); check("R3 disabled norm", v, 0);
    check("R3 irq_out low", {31'b0, irq_out}, 0);
    check("R9 raw wake", {31'b0, idle_wake}, 1);
  endtask

  task automatic t_route;
    logic [31:0] v;
    wr(8'h04, 32'h0000_00FF);
    wr(8'h08, 32'h0000_000F);
    rd(8'h10, v); check("R3 norm pend", v, 32'h0000_00A0);
    rd(8'h0C, v); check("R4 fast pend", v, 32'h0000_0005);
    check("R5 both lines", {30'b0, irq_out, fiq_out}, 32'h3);
    drive(32'h0000_0005);
    check("R5 only fast", {30'b0, irq_out, fiq_out}, 32'h1);
    drive(32'h0000_00A0);
    check("R5 only normal", {30'b0, irq_out, fiq_out}, 32'h2);
  endtask

  task automatic t_rank;
    logic [31:0] v;
    wr(8'h1C, 32'h8000_0003);
    wr(8'h20, 32'h8000_0007);
    wr(8'h24, 32'h8000_0005);
    drive(32'h0000_00A0);
    rd(8'h18, v); check("R6 slot1 wins", v, win(7));
    drive(32'h0000_0020);
    rd(8'h00, v); check("R11 fall clears", v, 32'h0000_0020);
    rd(8'h18, v); check("R6 next rank", v, win(5));
    drive(32'h0000_0028);
    rd(8'h18, v); check("R7 fast src not ranked", v, win(5));
    wr(8'h08, 32'h0000_0000);
    rd(8'h18, v); check("R6 slot0 after reroute", v, win(3));
    wr(8'h08, 32'h0000_000F);
  endtask

  task automatic t_none;
    logic [31:0] v;
    drive(32'h0);
    rd(8'h18, v); check("R7 idle", v, 0);
    drive(32'h0000_0020);
    wr(8'h24, 32'h0000_0005);
    rd(8'h18, v); check("R7 invalid slot", v, 0);
    check("R5 irq still up", {31'b0, irq_out}, 1);
  endtask

  task automatic t_slot_rw;
    logic [31:0] v;
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h2C, v); check("R8 slot fields", v, 32'h8000_001F);
    wr(8'h2C, 32'h7FFF_FFE2);
    rd(8'h2C, v); check("R8 slot invalid", v, 32'h0000_0002);
  endtask

  task automatic t_wake;
    wr(8'h04, 32'h0);
    wr(8'h14, 32'h1);
    drive(32'h0000_0001);
    check("R9 gated no wake", {31'b0, idle_wake}, 0);
    wr(8'h04, 32'h0000_0001);
    check("R9 gated wake", {31'b0, idle_wake}, 1);
    wr(8'h04, 32'h0);
    wr(8'h14, 32'h0);
    check("R9 raw mode wake", {31'b0, idle_wake}, 1);
  endtask

  task automatic t_ro;
    logic [31:0] v;
    wr(8'h04, 32'h0000_00F0);
    drive(32'h0000_0030);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R10 raw kept", v, 32'h0000_0030);
    rd(8'h04, v); check("R10 enable kept", v, 32'h0000_00F0);
    rd(8'h08, v); check("R10 route kept", v, 32'h0000_000F);
    rd(8'hFC, v); check("R10 unmapped", v, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_raw();
    t_route();
    t_rank();
    t_none();
    t_slot_rw();
    t_wake();
    t_ro();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule